// File: doc/BRIEF.md
# Sync Self-Test Pattern Generator

This block produces a free-running test raster from a 12 MHz clock: a horizontal sync, a vertical sync and a one-bit video level. A display controller uses it to drive a monitor path when no external sync is present, or to check that path. One of three fixed line rates is chosen, and one of four picture choices: a cross-hatch grid, the same grid inverted, solid white or solid black.

An enable input starts and stops the raster. While it is low, the position counters sit at the start of the first line and every output stays low. Raising it again starts a fresh frame from the first clock. A separate output enable gates only the video bit, so the sync pulses can keep running while the video bit is held low.

Top module: `sync_selftest_gen`

## Requirements
- R1: While `run_en` is 0, `test_hsync`, `test_vsync` and `stout` are 0 and the position is held at pixel 0 of line 0. After `run_en` rises, the first clock is pixel 0 of line 0.
- R2: The line period is 378 clocks for `hrate_sel` 2'b00 and 2'b01, 252 clocks for 2'b10 and 189 clocks for 2'b11.
- R3: With `pat_sel` 2'b00, `stout` is 1 when the pixel index within the line is a multiple of 32 or the line index within the frame is a multiple of 32. It is 0 otherwise. Both indices count from 0 at the start of the sync pulse.
- R4: With `pat_sel` 2'b01, `stout` is the inverse of the R3 grid.
- R5: With `pat_sel` 2'b10, `stout` is a constant 1. With 2'b11 it is a constant 0.
- R6: While `vout_en` is 0, `stout` is 0 whatever the pattern.
- R7: `test_hsync` is 1 for the first 8 clocks of every line and 0 for the rest of the line.
- R8: A frame is 525 lines. `test_vsync` is 1 for the first 3 whole lines of each frame and rises together with `test_hsync`.
- R9: An asynchronous reset returns the position to pixel 0 of line 0. If `run_en` is already 1, both sync outputs are 1 in the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | 1 runs the raster, 0 holds it idle |
| hrate_sel | input | 2 | Line rate choice |
| pat_sel | input | 2 | Picture choice |
| vout_en | input | 1 | 1 lets the picture reach `stout` |
| test_hsync | output | 1 | Horizontal test sync, active high |
| test_vsync | output | 1 | Vertical test sync, active high |
| stout | output | 1 | Test video level |

## Verification
The table of vectors samples the video bit at chosen pixel and line positions. Those positions separate a grid column, a grid row and an open cell, so the grid, its inverse, white and black each give a different result at the same point. Sample points on line 1 are chosen so that a wrong line length lands on a different grid cell, and this tells the three rates apart and shows that select 01 behaves like 00. Directed runs measure the sync pulse width, the line period at every rate, and the vertical pulse and frame length at the fastest rate. They also check that the raster restarts after a disable and after a reset.

// File: rtl/sync_selftest_gen.sv
module sync_selftest_gen #(
  parameter int HPER_SLOW = 378,
  parameter int HPER_MID  = 252,
  parameter int HPER_FAST = 189,
  parameter int LINES     = 525,
  parameter int HS_W      = 8,
  parameter int VS_LINES  = 3,
  parameter int GRID      = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic [1:0] hrate_sel,
  input  logic [1:0] pat_sel,
  input  logic       vout_en,
  output logic       test_hsync,
  output logic       test_vsync,
  output logic       stout
);
  localparam int HW = $clog2(HPER_SLOW + 1);
  localparam int VW = $clog2(LINES + 1);
  localparam int GB = $clog2(GRID);

  logic [HW-1:0] hcnt, hper;
  logic [VW-1:0] vcnt;
  logic          line_end, frame_end, hatch, pix;

  always_comb begin
    case (hrate_sel)
      2'b10:   hper = HW'(HPER_MID);
      2'b11:   hper = HW'(HPER_FAST);
      default: hper = HW'(HPER_SLOW);
    endcase
  end

  assign line_end  = hcnt >= hper - HW'(1);
  assign frame_end = vcnt >= VW'(LINES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!run_en) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + VW'(1);
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  assign hatch = (hcnt[GB-1:0] == '0) || (vcnt[GB-1:0] == '0);

  always_comb begin
    case (pat_sel)
      2'b00: pix = hatch;
      2'b01: pix = ~hatch;
      2'b10: pix = 1'b1;
      default: pix = 1'b0;
    endcase
  end

  assign test_hsync = run_en && (hcnt < HW'(HS_W));
  assign test_vsync = run_en && (vcnt < VW'(VS_LINES));
  assign stout      = run_en && vout_en && pix;
endmodule

module sync_selftest_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_en,
  input logic       vout_en,
  input logic [1:0] pat_sel,
  input logic       test_hsync,
  input logic       test_vsync,
  input logic       stout
);
  logic [7:0] hs_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_run <= '0;
    else if (test_hsync) hs_run <= hs_run + 8'd1;
    else hs_run <= '0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !test_hsync && !test_vsync && !stout);

  assert_white_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && vout_en && pat_sel == 2'b10 |-> stout);

  assert_video_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vout_en |-> !stout);

  assert_hsync_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_hsync) && run_en |-> hs_run == 8'd8);

  assert_vsync_on_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_vsync != $past(test_vsync)) && run_en && $past(run_en) |-> $rose(test_hsync));
endmodule

bind sync_selftest_gen sync_selftest_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .vout_en(vout_en),
  .pat_sel(pat_sel), .test_hsync(test_hsync), .test_vsync(test_vsync),
  .stout(stout)
);

// File: tb/sync_selftest_gen_tb.sv
`timescale 1ns/1ps
module sync_selftest_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, vout_en = 1'b0;
  logic [1:0] hrate_sel = 2'b00, pat_sel = 2'b00;
  logic test_hsync, test_vsync, stout;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_selftest_gen u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .hrate_sel(hrate_sel),
    .pat_sel(pat_sel), .vout_en(vout_en), .test_hsync(test_hsync),
    .test_vsync(test_vsync), .stout(stout)
  );

  // {rate[1:0], pat[1:0], vout_en, run_en, clocks after enable[18:0], expected stout}
  localparam int NV = 16;
  localparam logic [25:0] VEC [NV] = '{
    {2'b11, 2'b00, 1'b1, 1'b1, 19'd0,    1'b1},  // R3 line 0 pixel 0
    {2'b11, 2'b00, 1'b1, 1'b1, 19'd194,  1'b0},  // R3 open cell
    {2'b11, 2'b00, 1'b1, 1'b1, 19'd221,  1'b1},  // R3 column 32
    {2'b11, 2'b01, 1'b1, 1'b1, 19'd194,  1'b1},  // R4
    {2'b11, 2'b01, 1'b1, 1'b1, 19'd221,  1'b0},  // R4
    {2'b11, 2'b10, 1'b1, 1'b1, 19'd194,  1'b1},  // R5 white
    {2'b11, 2'b11, 1'b1, 1'b1, 19'd221,  1'b0},  // R5 black
    {2'b11, 2'b00, 1'b0, 1'b1, 19'd221,  1'b0},  // R6
    {2'b11, 2'b10, 1'b0, 1'b1, 19'd194,  1'b0},  // R6
    {2'b00, 2'b00, 1'b1, 1'b1, 19'd380,  1'b0},  // R2 378 clocks
    {2'b01, 2'b00, 1'b1, 1'b1, 19'd380,  1'b0},  // R2 01 as 00
    {2'b10, 2'b00, 1'b1, 1'b1, 19'd256,  1'b0},  // R2 252 clocks
    {2'b11, 2'b00, 1'b1, 1'b1, 19'd6053, 1'b1},  // R3 row 32
    {2'b11, 2'b00, 1'b1, 1'b1, 19'd5864, 1'b0},  // R3 line 31
    {2'b11, 2'b10, 1'b1, 1'b0, 19'd10,   1'b0},  // R1 idle
    {2'b00, 2'b00, 1'b1, 1'b1, 19'd442,  1'b1}   // R2 column 64 on line 1
  };

  function automatic string req_of(input logic [1:0] r, input logic [1:0] p,
                                   input logic v, input logic g);
    if (!g) return "R1";
    if (!v) return "R6";
    if (p == 2'b01) return "R4";
    if (p[1]) return "R5";
    if (r != 2'b11) return "R2";
    return "R3";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] r, input logic [1:0] p, input logic v);
    @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    hrate_sel = r; pat_sel = p; vout_en = v; run_en = 1'b1;
  endtask

  task automatic line_timing(input logic [1:0] r, input int exp_per);
    int n = 0, fall_at = -1;
    restart(r, 2'b00, 1'b1);
    while (n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (fall_at >= 0 && test_hsync) break;
      if (!test_hsync && fall_at < 0) fall_at = n;
    end
    check("R7", fall_at, 8);
    check("R2", n, exp_per);
  endtask

  initial begin
    #950000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {test_hsync, test_vsync, stout}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [25:0] e;
      e = VEC[i];
      @(negedge clk);
      run_en = 1'b0;
      @(negedge clk);
      hrate_sel = e[25:24]; pat_sel = e[23:22]; vout_en = e[21]; run_en = e[20];
      repeat (int'(e[19:1])) @(posedge clk);
      @(negedge clk);
      check(req_of(e[25:24], e[23:22], e[21], e[20]), stout, e[0]);
    end

    line_timing(2'b00, 378);
    line_timing(2'b01, 378);
    line_timing(2'b10, 252);
    line_timing(2'b11, 189);

    begin
      int n = 0, vfall = -1;
      restart(2'b11, 2'b00, 1'b1);
      #1;
      check("R8", test_vsync, 1);
      while (n < 110000) begin
        @(posedge clk); n++;
        @(negedge clk);
        if (vfall >= 0 && test_vsync) break;
        if (!test_vsync && vfall < 0) vfall = n;
      end
      check("R8", vfall, 567);
      check("R8", n, 99225);
      check("R8", test_hsync, 1);
    end

    restart(2'b11, 2'b10, 1'b1);
    repeat (100) @(posedge clk);
    @(negedge clk);
    run_en = 1'b0;
    #1;
    check("R1", {test_hsync, test_vsync, stout}, 0);
    @(negedge clk);
    run_en = 1'b1;
    #1;
    check("R1", {test_hsync, test_vsync}, 3);

    repeat (20) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (9) @(posedge clk);
    @(negedge clk);
    check("R9", test_hsync, 0);
    repeat (180) @(posedge clk);
    @(negedge clk);
    check("R9", {test_hsync, test_vsync}, 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule